// File: doc/BRIEF.md
# GPIO Bank with Interrupt Cause Logic

This block is a 32-pin general-purpose I/O bank. Software reaches it through a simple memory-mapped register port. Each pin can be an output, driven either from a stored value or from a shared blink oscillator, or an input. An input is first passed through a two-flop synchroniser. It is then XORed with a per-pin polarity bit. The polarity-adjusted value is what software reads back.

The polarity-adjusted input feeds two interrupt paths. The level path ANDs the adjusted value with a level-enable mask. The edge path latches every 0-to-1 transition of the adjusted value into a sticky cause register, which is gated by an edge-enable mask. Inverting a pin's polarity therefore turns the single rising-edge detector into a falling-edge detector. Software can also flip the polarity after each event to catch both edges.

The per-pin requests are OR-reduced in groups of eight pins onto four summary interrupt lines. The blink half period is a parameter given in clock cycles. All blinking pins share one divider, so they toggle together.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is an input (direction register reads 0xFFFFFFFF, `pinOe` is 0), `pinOut` is 0, `irqGroup` is 0, and the edge cause, edge enable and level enable registers read 0.
- R2: Registers sit at byte offsets 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x10 input data (read-only), 0x14 edge cause, 0x18 edge enable, 0x1C level enable. Writable registers read back what was written. Misaligned accesses read 0 and write nothing. Writes to 0x10 have no effect.
- R3: Direction bit 1 makes the pin an input with `pinOe` low and `pinOut` low. Direction bit 0 drives `pinOe` high and `pinOut` from the output-value bit, one clock edge after the write.
- R4: Reading 0x10 returns the pin level XOR the polarity bit. The pin level is taken through a two-flop synchroniser, so a pin change shows up after the second rising clock edge.
- R5: A pin's level request is its adjusted input bit AND its level-enable bit. The request follows the pin and drops when the pin returns low.
- R6: A 0-to-1 transition of the adjusted input bit sets that pin's edge cause bit on the third rising edge after the pin change. The bit then stays set after the pin returns low.
- R7: A write to 0x14 clears the cause bits written as 0 and keeps those written as 1. If a new edge arrives in the same cycle as a clearing write, the bit ends up set.
- R8: A set edge cause bit raises an interrupt only while its edge-enable bit is 1.
- R9: `irqGroup[g]` is the OR of the level and edge requests of pins 8g to 8g+7, for g = 0 to 3.
- R10: With the polarity bit at 1, a falling pin sets the edge cause bit. A rising pin then does not set it.
- R11: A pin with its blink bit set and its direction bit 0 toggles every `BLINK_HALF` cycles, in phase with every other blinking pin. A blink bit on an input pin drives nothing. When the blink bit is cleared, the pin follows its output value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (5) | Byte address |
| busWdata | input | NUM_PINS (32) | Write data |
| busRdata | output | NUM_PINS (32) | Read data, combinational |
| pinIn | input | NUM_PINS (32) | Asynchronous pin levels |
| pinOut | output | NUM_PINS (32) | Pin drive values |
| pinOe | output | NUM_PINS (32) | Pin output enables |
| irqGroup | output | NUM_PINS/GROUP_SIZE (4) | Summary interrupt per group of eight pins |

## Verification
Each result has its own due time. A register write is visible after one clock edge. A pin change reaches the input-data register and the level request after two edges, and reaches the edge cause register after three. A blinking output changes every `BLINK_HALF` edges. The bench drives stimulus just after a falling edge and counts rising edges one by one before it samples, a short delay after the next falling edge. The same-cycle clear-and-set race is hit by placing the clearing write on exactly the third edge after a pin change. The synchroniser delay is checked by sampling the input data after one edge (still old) as well as after two.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register select; the enum order follows the word index of the address map.
  typedef enum logic [2:0] {
    RS_OUT   = 3'd0,
    RS_DIR   = 3'd1,
    RS_BLINK = 3'd2,
    RS_POL   = 3'd3,
    RS_DIN   = 3'd4,
    RS_CAUSE = 3'd5,
    RS_EMASK = 3'd6,
    RS_LMASK = 3'd7
  } regSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    wrOut;
    logic    wrDir;
    logic    wrBlink;
    logic    wrPol;
    logic    wrCause;
    logic    wrEMask;
    logic    wrLMask;
    logic    rdValid;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);

  localparam int LSB_W = 2;
  localparam int IDX_W = 3;
  localparam int TOP_W = LSB_W + IDX_W;

  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             wrEn;
  regSel_e          sel;

  always_comb begin
    idx  = busAddr[TOP_W-1:LSB_W];
    sel  = regSel_e'(idx);
    hit  = busSel && (busAddr[LSB_W-1:0] == '0) && ((busAddr >> TOP_W) == '0);
    wrEn = hit && busWr;

    strb         = '0;
    strb.rdSel   = sel;
    strb.rdValid = hit && !busWr;

    if (wrEn) begin
      case (sel)
        RS_OUT:   strb.wrOut   = 1'b1;
        RS_DIR:   strb.wrDir   = 1'b1;
        RS_BLINK: strb.wrBlink = 1'b1;
        RS_POL:   strb.wrPol   = 1'b1;
        RS_CAUSE: strb.wrCause = 1'b1;
        RS_EMASK: strb.wrEMask = 1'b1;
        RS_LMASK: strb.wrLMask = 1'b1;
        default:  ;  // input data is read-only
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= dIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
  parameter int HALF_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rstN,
  output logic phase
);

  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BLINK_HALF  = 10_000_000,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [NUM_PINS-1:0]   wdata,
  output logic [NUM_PINS-1:0]   rdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_GROUPS-1:0] irqGroup,
  output logic [NUM_PINS-1:0]   causeQ,
  output logic [NUM_PINS-1:0]   riseVec,
  output logic [NUM_PINS-1:0]   dirQ,
  output logic [NUM_PINS-1:0]   blinkQ,
  output logic [NUM_PINS-1:0]   eMaskQ,
  output logic [NUM_PINS-1:0]   lMaskQ
);

  logic [NUM_PINS-1:0] outQ;
  logic [NUM_PINS-1:0] polQ;
  logic [NUM_PINS-1:0] syncVal;
  logic [NUM_PINS-1:0] dinVal;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] causeNext;
  logic [NUM_PINS-1:0] reqVec;
  logic [NUM_PINS-1:0] drvVal;
  logic                blinkPhase;

  gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (pinIn),
    .dOut (syncVal)
  );

  gpio_bank_blink #(.HALF_CYCLES(BLINK_HALF)) uBlink (
    .clk   (clk),
    .rstN  (rstN),
    .phase (blinkPhase)
  );

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ   <= '0;
      dirQ   <= '1;
      blinkQ <= '0;
      polQ   <= '0;
      eMaskQ <= '0;
      lMaskQ <= '0;
    end else begin
      if (strb.wrOut)   outQ   <= wdata;
      if (strb.wrDir)   dirQ   <= wdata;
      if (strb.wrBlink) blinkQ <= wdata;
      if (strb.wrPol)   polQ   <= wdata;
      if (strb.wrEMask) eMaskQ <= wdata;
      if (strb.wrLMask) lMaskQ <= wdata;
    end
  end

  // Polarity adjust and rising-edge detect on the adjusted value
  assign dinVal  = syncVal ^ polQ;
  assign riseVec = dinVal & ~prevQ;

  // Acknowledge keeps bits written as 1; a fresh edge always wins
  always_comb begin
    causeNext = causeQ;
    if (strb.wrCause) causeNext = causeQ & wdata;
    causeNext = causeNext | riseVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      causeQ <= '0;
    end else begin
      prevQ  <= dinVal;
      causeQ <= causeNext;
    end
  end

  // Per-pin drive and request
  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    assign drvVal[i] = blinkQ[i] ? blinkPhase : outQ[i];
    assign pinOe[i]  = ~dirQ[i];
    assign pinOut[i] = ~dirQ[i] & drvVal[i];
    assign reqVec[i] = (dinVal[i] & lMaskQ[i]) | (causeQ[i] & eMaskQ[i]);
  end

  // Group reduction
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign irqGroup[g] = |reqVec[g*GROUP_SIZE +: GROUP_SIZE];
  end

  // Read mux
  always_comb begin
    rdata = '0;
    if (strb.rdValid) begin
      case (strb.rdSel)
        RS_OUT:   rdata = outQ;
        RS_DIR:   rdata = dirQ;
        RS_BLINK: rdata = blinkQ;
        RS_POL:   rdata = polQ;
        RS_DIN:   rdata = dinVal;
        RS_CAUSE: rdata = causeQ;
        RS_EMASK: rdata = eMaskQ;
        RS_LMASK: rdata = lMaskQ;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int BLINK_HALF  = 10_000_000,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [NUM_PINS-1:0]   busWdata,
  output logic [NUM_PINS-1:0]   busRdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_GROUPS-1:0] irqGroup
);

  ctrlStrobe_t         strb;
  logic [NUM_PINS-1:0] causeQ;
  logic [NUM_PINS-1:0] riseVec;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] blinkQ;
  logic [NUM_PINS-1:0] eMaskQ;
  logic [NUM_PINS-1:0] lMaskQ;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_bank_dp #(
    .NUM_PINS    (NUM_PINS),
    .GROUP_SIZE  (GROUP_SIZE),
    .SYNC_STAGES (SYNC_STAGES),
    .BLINK_HALF  (BLINK_HALF)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (busWdata),
    .rdata    (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqGroup (irqGroup),
    .causeQ   (causeQ),
    .riseVec  (riseVec),
    .dirQ     (dirQ),
    .blinkQ   (blinkQ),
    .eMaskQ   (eMaskQ),
    .lMaskQ   (lMaskQ)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS   = 32,
  parameter int ADDR_W     = 5,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busWr,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [NUM_PINS-1:0]   busWdata,
  input logic [NUM_PINS-1:0]   pinOut,
  input logic [NUM_PINS-1:0]   pinOe,
  input logic [NUM_GROUPS-1:0] irqGroup,
  input logic [NUM_PINS-1:0]   causeQ,
  input logic [NUM_PINS-1:0]   riseVec,
  input logic [NUM_PINS-1:0]   dirQ,
  input logic [NUM_PINS-1:0]   blinkQ,
  input logic [NUM_PINS-1:0]   eMaskQ,
  input logic [NUM_PINS-1:0]   lMaskQ
);

  logic                wrDirSeen;
  logic                wrCauseSeen;
  logic [NUM_PINS-1:0] blinkAct;

  assign wrDirSeen   = busSel && busWr && (busAddr == ADDR_W'(4));
  assign wrCauseSeen = busSel && busWr && (busAddr == ADDR_W'(20));
  assign blinkAct    = blinkQ & ~dirQ;

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rstN)
    wrDirSeen |=> (pinOe == ~$past(busWdata))); // R3

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrCauseSeen) |-> (($past(causeQ) & ~causeQ) == '0)); // R6

  AST_EDGE_ALWAYS_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (riseVec != '0) |=> ((causeQ & $past(riseVec)) == $past(riseVec))); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrCauseSeen |=> ((causeQ & ~$past(busWdata) & ~$past(riseVec)) == '0)); // R7

  AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    ((eMaskQ == '0) && (lMaskQ == '0)) |-> (irqGroup == '0)); // R9

  AST_BLINK_IN_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (blinkAct != '0) |-> (($countones(pinOut & blinkAct) == 0) ||
                          ($countones(pinOut & blinkAct) == $countones(blinkAct)))); // R11

endmodule

bind gpio_irq_bank gpio_bank_chk #(
  .NUM_PINS   (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .NUM_GROUPS (NUM_GROUPS)
) uChk (.*);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 32;
  localparam int AW         = 5;
  localparam int HALF       = 4;
  localparam int WDOG       = 20000;

  localparam logic [AW-1:0] A_OUT = 5'h00, A_DIR = 5'h04, A_BLK = 5'h08, A_POL = 5'h0C,
                            A_DIN = 5'h10, A_CAU = 5'h14, A_EMS = 5'h18, A_LMS = 5'h1C;

  // {address, write data, expected read-back}
  localparam int NVEC = 9;
  localparam logic [68:0] VEC [NVEC] = '{
    {5'h00, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {5'h02, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h04, 32'h1234_5678, 32'h1234_5678},
    {5'h08, 32'h00F0_00F0, 32'h00F0_00F0},
    {5'h0C, 32'h0000_FFFF, 32'h0000_FFFF},
    {5'h10, 32'hFFFF_FFFF, 32'h0000_FFFF},
    {5'h18, 32'hC000_0003, 32'hC000_0003},
    {5'h1C, 32'h00FF_0000, 32'h00FF_0000},
    {5'h14, 32'hFFFF_FFFF, 32'h0000_FFFF}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [N-1:0]  busWdata = '0;
  logic [N-1:0]  busRdata;
  logic [N-1:0]  pinIn = '0;
  logic [N-1:0]  pinOut;
  logic [N-1:0]  pinOe;
  logic [3:0]    irqGroup;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(N), .ADDR_W(AW), .BLINK_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqGroup(irqGroup)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [N-1:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [N-1:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic quiesce();
    pinIn = '0;
    busWrite(A_EMS, '0);
    busWrite(A_LMS, '0);
    busWrite(A_POL, '0);
    repeat (4) tick();
    busWrite(A_CAU, '0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    #1;
    chk("R1 pinOe", pinOe, '0);
    chk("R1 pinOut", pinOut, '0);
    chk("R1 irq", {28'd0, irqGroup}, '0);
    busRead(A_DIR, rd); chk("R1 dir", rd, 32'hFFFF_FFFF);
    busRead(A_CAU, rd); chk("R1 cause", rd, '0);
    busRead(A_EMS, rd); chk("R1 emask", rd, '0);
    busRead(A_LMS, rd); chk("R1 lmask", rd, '0);

    // R2 register table
    for (int v = 0; v < NVEC; v++) begin
      busWrite(VEC[v][68:64], VEC[v][63:32]);
      busRead(VEC[v][68:64], rd);
      chk($sformatf("R2 vec%0d", v), rd, VEC[v][31:0]);
    end
    busRead(A_OUT, rd); chk("R2 misaligned write ignored", rd, 32'hA5A5_5A5A);
    quiesce();
    busWrite(A_BLK, '0);
    busWrite(A_OUT, '0);

    // R3 direction and output value
    busWrite(A_DIR, 32'hFFFF_0000);
    busWrite(A_OUT, 32'h0001_00C3);
    #1;
    chk("R3 pinOe", pinOe, 32'h0000_FFFF);
    chk("R3 pinOut", pinOut, 32'h0000_00C3);
    busWrite(A_DIR, 32'hFFFF_FFFF);
    #1;
    chk("R3 all inputs", pinOut | pinOe, '0);

    // R4 synchroniser delay and polarity
    tick();
    pinIn = 32'h8000_0001;
    tick();
    busRead(A_DIN, rd); chk("R4 one edge still old", rd, '0);
    tick();
    busRead(A_DIN, rd); chk("R4 two edges", rd, 32'h8000_0001);
    busWrite(A_POL, 32'h0000_0003);
    busRead(A_DIN, rd); chk("R4 polarity", rd, 32'h8000_0002);
    quiesce();

    // R5 level request
    busWrite(A_LMS, 32'h0000_0100);
    pinIn = 32'h0000_0200;
    repeat (3) tick(); #1;
    chk("R5 unmasked pin silent", {28'd0, irqGroup}, '0);
    tick();
    pinIn = 32'h0000_0100;
    tick(); #1;
    chk("R5 not before sync", {28'd0, irqGroup}, '0);
    tick(); #1;
    chk("R5 level raised", {28'd0, irqGroup}, 32'h2);
    pinIn = '0;
    repeat (2) tick(); #1;
    chk("R5 level follows pin", {28'd0, irqGroup}, '0);
    quiesce();

    // R6 edge latch, R8 edge mask
    pinIn = 32'h0002_0000;
    repeat (2) tick();
    busRead(A_CAU, rd); chk("R6 not yet latched", rd, '0);
    tick();
    busRead(A_CAU, rd); chk("R6 latched third edge", rd, 32'h0002_0000);
    chk("R8 masked edge silent", {28'd0, irqGroup}, '0);
    pinIn = '0;
    repeat (4) tick();
    busRead(A_CAU, rd); chk("R6 sticky", rd, 32'h0002_0000);
    busWrite(A_EMS, 32'h0002_0000);
    #1;
    chk("R8 enabled edge irq", {28'd0, irqGroup}, 32'h4);

    // R7 acknowledge
    busWrite(A_CAU, 32'hFFFF_FFFF);
    busRead(A_CAU, rd); chk("R7 write one keeps", rd, 32'h0002_0000);
    busWrite(A_CAU, ~32'h0002_0000);
    busRead(A_CAU, rd); chk("R7 write zero clears", rd, '0);
    #1;
    chk("R7 irq dropped", {28'd0, irqGroup}, '0);
    quiesce();

    // R7 set wins over a clearing write in the same cycle
    pinIn = 32'h0000_0008;
    repeat (4) tick();
    pinIn = 32'h0010_0008;
    repeat (2) tick();
    busWrite(A_CAU, 32'h0000_0000);
    busRead(A_CAU, rd); chk("R7 set wins", rd, 32'h0010_0000);
    quiesce();

    // R10 falling edge via polarity
    pinIn = 32'h0400_0000;
    repeat (4) tick();
    busWrite(A_CAU, '0);
    busWrite(A_POL, 32'h0400_0000);
    repeat (3) tick();
    busRead(A_CAU, rd); chk("R10 no rise seen", rd, '0);
    pinIn = '0;
    repeat (3) tick();
    busRead(A_CAU, rd); chk("R10 falling latched", rd, 32'h0400_0000);
    busWrite(A_CAU, '0);
    pinIn = 32'h0400_0000;
    repeat (4) tick();
    busRead(A_CAU, rd); chk("R10 rising ignored", rd, '0);
    quiesce();

    // R9 group reduction
    busWrite(A_LMS, 32'hFFFF_FFFF);
    for (int g = 0; g < 4; g++) begin
      pinIn = 32'h1 << (g * 8 + 7 - g);
      repeat (3) tick(); #1;
      chk($sformatf("R9 group%0d", g), {28'd0, irqGroup}, 32'h1 << g);
    end
    pinIn = 32'h0100_0001;
    repeat (3) tick(); #1;
    chk("R9 two groups", {28'd0, irqGroup}, 32'h9);
    quiesce();

    // R11 blink
    busWrite(A_DIR, 32'hFFFF_FFF0);
    busWrite(A_OUT, 32'h0000_000F);
    busWrite(A_BLK, 32'h0000_0105);
    begin
      int toggles = 0;
      int lastT = -1;
      int gapBad = 0;
      int mism = 0;
      logic prevP = 1'b0;
      for (int k = 0; k < 24; k++) begin
        tick(); #1;
        if (k > 0 && pinOut[0] != prevP) begin
          if (lastT >= 0 && (k - lastT) != HALF) gapBad++;
          lastT = k;
          toggles++;
        end
        prevP = pinOut[0];
        if (pinOut[2] != pinOut[0] || pinOut[1] != 1'b1 || pinOut[3] != 1'b1 ||
            pinOe[8] != 1'b0 || pinOut[8] != 1'b0) mism++;
      end
      chk("R11 toggle count", (toggles >= 4) ? 32'd1 : 32'd0, 32'd1);
      chk("R11 half period", gapBad, 32'd0);
      chk("R11 phase and input pin", mism, 32'd0);
    end
    busWrite(A_BLK, '0);
    #1;
    chk("R11 blink off follows value", pinOut, 32'h0000_000F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule